// File: doc/BRIEF.md
# Interrupt Source Selector and Type Encoder

This block gathers every condition that can interrupt a small 16-bit processor core and turns them into at most one pending request with an 8-bit type number. Faults and interrupt instructions arrive from the execute stage as strobes. These are the divide fault, the software interrupt with its operand byte, the one-byte breakpoint, and the overflow-check instruction together with the live overflow flag. The block also receives the two external request pins, the byte that goes with the maskable pin, the interrupt-enable and single-step flags, and a strobe marking the end of each instruction.

The non-maskable pin first passes through a synchronizer. Its rising edge is then held in a one-deep latch until that request is acknowledged. All other sources are sampled only on an end-of-instruction cycle, and a fixed priority order picks the winner. The winner is registered and held on the outputs until the core acknowledges it. The core then pushes state, fetches the vector for the given type and later resumes. Those steps lie outside this block.

Top module: `irq_type_select`

## Requirements
- R1: During reset and in the first cycle after it, `irq_valid` is 0.
- R2: A divide fault at an instruction boundary yields type 0x00.
- R3: When `tf_flag` is 1 at a boundary and no other source qualifies, type 0x01 is raised.
- R4: A low-to-high change on `nmi_pin` raises type 0x02 at the first boundary after the edge has passed the SYNC_STAGES synchronizer plus one latch register, whatever the state of `if_flag`. A pin held high gives exactly one request.
- R5: A breakpoint strobe at a boundary yields type 0x03.
- R6: The overflow-check strobe yields type 0x04 only when `of_flag` is 1. When `of_flag` is 0 it contributes nothing.
- R7: A software interrupt strobe yields its operand `swi_num` (0x00 to 0xFF) unchanged as the type.
- R8: `intr_pin` yields type `intr_type` only when `if_flag` is 1 at the boundary. When `if_flag` is 0 it is ignored.
- R9: At one boundary, the sources rank as follows: divide fault, then software interrupt, then breakpoint, then overflow check, then latched NMI, then maskable pin, then single-step. Only the highest-ranked source is taken.
- R10: A request appears one cycle after its boundary. `irq_type` stays unchanged while `irq_valid` is 1 and `irq_ack` is 0, and `irq_valid` falls in the cycle after `irq_ack`. A boundary that arrives while a request is pending, including the acknowledge cycle, is ignored.
- R11: The latched NMI is cleared only when an NMI request is acknowledged. Several edges before that acknowledge produce one request. An edge in the acknowledge cycle itself is kept.
- R12: Without `ex_done`, no strobe, pin or flag starts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin, asynchronous |
| intr_pin | input | 1 | Maskable request level, synchronous to clk |
| intr_type | input | 8 | Type byte supplied with the maskable request |
| if_flag | input | 1 | Interrupt-enable flag |
| tf_flag | input | 1 | Single-step flag |
| ex_done | input | 1 | End-of-instruction strobe |
| ex_div_err | input | 1 | Divide fault of the finishing instruction |
| ex_swi | input | 1 | Finishing instruction is a software interrupt |
| swi_num | input | 8 | Software interrupt operand |
| ex_brk | input | 1 | Finishing instruction is the breakpoint |
| ex_into | input | 1 | Finishing instruction is the overflow check |
| of_flag | input | 1 | Overflow flag |
| irq_ack | input | 1 | Core accepts the pending request |
| irq_valid | output | 1 | A request is pending |
| irq_type | output | 8 | Type number of the pending request |

## Verification
The bench builds the block with SYNC_STAGES=2. This puts a three-cycle gap between an NMI edge and the first boundary that can take it. Within that gap the bench places boundaries, acknowledges and repeated pulses, and these show whether an edge is counted too early, counted twice, or lost while the core is acknowledging. A long random phase sets many sources against one another at the same boundaries, and this exercises the whole priority chain and the masking by the interrupt-enable flag.

// File: rtl/irq_sel_pkg.sv
// Shared constants and types for the interrupt source selector.
// Assumes: type numbers are one byte wide, as the vector scheme requires.
package irq_sel_pkg;
    localparam int TYPE_W = 8;

    localparam logic [TYPE_W-1:0] TYPE_DIV  = 8'h00;
    localparam logic [TYPE_W-1:0] TYPE_STEP = 8'h01;
    localparam logic [TYPE_W-1:0] TYPE_NMI  = 8'h02;
    localparam logic [TYPE_W-1:0] TYPE_BRK  = 8'h03;
    localparam logic [TYPE_W-1:0] TYPE_OVF  = 8'h04;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXC,
        SRC_NMI,
        SRC_INTR,
        SRC_TRAP
    } irq_src_e;
endpackage

// File: rtl/irq_nmi_capture.sv
// Synchronizes the NMI pin, detects its rising edge and holds one pending
// event until cleared. Assumes: the pin is asynchronous to clk; a new edge
// in the clear cycle wins over the clear.
module irq_nmi_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    logic synced;
    logic synced_q;
    logic rise;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign synced = pin;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] stg;
            // Shift the pin through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg <= '0;
                end else begin
                    stg[0] <= pin;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end
            assign synced = stg[SYNC_STAGES-1];
        end
    endgenerate

    assign rise = synced & ~synced_q;

    // Remember the previous synchronized level and hold the pending event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            pend     <= 1'b0;
        end else begin
            synced_q <= synced;
            pend     <= (pend & ~clr) | rise;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority choice among all request conditions, purely combinational.
// Assumes: the result is only used on an instruction-boundary cycle.
module irq_prio_sel
    import irq_sel_pkg::*;
(
    input  logic              div_err,
    input  logic              swi,
    input  logic [TYPE_W-1:0] swi_num,
    input  logic              brk,
    input  logic              into,
    input  logic              of_flag,
    input  logic              nmi_pend,
    input  logic              intr_pin,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              if_flag,
    input  logic              tf_flag,
    output logic              hit,
    output irq_src_e          src,
    output logic [TYPE_W-1:0] typ
);
    // Walk the sources from highest to lowest rank.
    always_comb begin
        hit = 1'b1;
        src = SRC_EXC;
        typ = '0;
        if (div_err) begin
            typ = TYPE_DIV;
        end else if (swi) begin
            typ = swi_num;
        end else if (brk) begin
            typ = TYPE_BRK;
        end else if (into && of_flag) begin
            typ = TYPE_OVF;
        end else if (nmi_pend) begin
            src = SRC_NMI;
            typ = TYPE_NMI;
        end else if (intr_pin && if_flag) begin
            src = SRC_INTR;
            typ = intr_type;
        end else if (tf_flag) begin
            src = SRC_TRAP;
            typ = TYPE_STEP;
        end else begin
            hit = 1'b0;
            src = SRC_NONE;
        end
    end
endmodule

// File: rtl/irq_hold.sv
// Captures the winning request at a boundary and holds it until acknowledged.
// Assumes: boundaries seen while a request is pending are dropped.
module irq_hold
    import irq_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              hit,
    input  irq_src_e          sel_src,
    input  logic [TYPE_W-1:0] sel_type,
    input  logic              ack,
    output logic              valid,
    output irq_src_e          src,
    output logic [TYPE_W-1:0] typ
);
    // Load on a boundary when idle, release one cycle after acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            src   <= SRC_NONE;
            typ   <= '0;
        end else if (valid) begin
            if (ack) begin
                valid <= 1'b0;
                src   <= SRC_NONE;
            end
        end else if (boundary && hit) begin
            valid <= 1'b1;
            src   <= sel_src;
            typ   <= sel_type;
        end
    end
endmodule

// File: rtl/irq_type_select.sv
// Top of the interrupt source selector: NMI capture, priority choice and the
// output holding register. Assumes: intr_pin, flags and strobes are synchronous
// to clk; execute-stage strobes are only meaningful together with ex_done.
module irq_type_select
    import irq_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              if_flag,
    input  logic              tf_flag,
    input  logic              ex_done,
    input  logic              ex_div_err,
    input  logic              ex_swi,
    input  logic [TYPE_W-1:0] swi_num,
    input  logic              ex_brk,
    input  logic              ex_into,
    input  logic              of_flag,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [TYPE_W-1:0] irq_type
);
    logic              nmi_pend;
    logic              nmi_clr;
    logic              sel_hit;
    irq_src_e          sel_src;
    logic [TYPE_W-1:0] sel_type;
    irq_src_e          held_src;

    assign nmi_clr = irq_valid & irq_ack & (held_src == SRC_NMI);

    irq_nmi_capture #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (nmi_pin),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    irq_prio_sel u_sel (
        .div_err   (ex_div_err),
        .swi       (ex_swi),
        .swi_num   (swi_num),
        .brk       (ex_brk),
        .into      (ex_into),
        .of_flag   (of_flag),
        .nmi_pend  (nmi_pend),
        .intr_pin  (intr_pin),
        .intr_type (intr_type),
        .if_flag   (if_flag),
        .tf_flag   (tf_flag),
        .hit       (sel_hit),
        .src       (sel_src),
        .typ       (sel_type)
    );

    irq_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (ex_done),
        .hit      (sel_hit),
        .sel_src  (sel_src),
        .sel_type (sel_type),
        .ack      (irq_ack),
        .valid    (irq_valid),
        .src      (held_src),
        .typ      (irq_type)
    );
endmodule

// File: rtl/irq_type_select_chk.sv
// Property checker for irq_type_select, attached through bind below.
module irq_type_select_chk
    import irq_sel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_valid,
    input logic [TYPE_W-1:0] irq_type,
    input logic              irq_ack,
    input logic              ex_done,
    input logic              if_flag,
    input logic              tf_flag,
    input irq_src_e          held_src,
    input logic              nmi_pend
);
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_type)));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> !irq_valid);

    a_r12_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(ex_done));

    a_r8_intr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && held_src == SRC_INTR) |-> $past(if_flag));

    a_r3_trap_type: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && held_src == SRC_TRAP) |-> ($past(tf_flag) && irq_type == TYPE_STEP));

    a_r11_nmi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !(irq_valid && irq_ack && held_src == SRC_NMI)) |=> nmi_pend);
endmodule

bind irq_type_select irq_type_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid),
    .irq_type  (irq_type),
    .irq_ack   (irq_ack),
    .ex_done   (ex_done),
    .if_flag   (if_flag),
    .tf_flag   (tf_flag),
    .held_src  (held_src),
    .nmi_pend  (nmi_pend)
);

// File: tb/irq_type_select_test.sv
// Bench: behavioural reference model updated each rising edge, compared with
// the outputs on every falling edge; inputs change on falling edges only.
module irq_type_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 0, intr_pin = 0, if_flag = 0, tf_flag = 0;
    logic [7:0] intr_type = 0, swi_num = 0;
    logic       ex_done = 0, ex_div_err = 0, ex_swi = 0, ex_brk = 0, ex_into = 0, of_flag = 0;
    logic       irq_ack = 0;
    logic       irq_valid;
    logic [7:0] irq_type;

    irq_type_select #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .intr_pin(intr_pin),
        .intr_type(intr_type), .if_flag(if_flag), .tf_flag(tf_flag),
        .ex_done(ex_done), .ex_div_err(ex_div_err), .ex_swi(ex_swi),
        .swi_num(swi_num), .ex_brk(ex_brk), .ex_into(ex_into), .of_flag(of_flag),
        .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_type(irq_type)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";

    // Reference model state
    bit       m_valid, m_nmi_src, m_pend, m_prev, m_sync, m_rise, m_clr, m_old_pend;
    bit [7:0] m_type;
    string    m_tag = "R10";
    bit       m_hist[$];

    task automatic take(input bit [7:0] t, input string tag, input bit is_nmi);
        m_valid   = 1'b1;
        m_type    = t;
        m_tag     = tag;
        m_nmi_src = is_nmi;
    endtask

    always @(posedge clk) begin : model
        if (!rst_n) begin
            m_valid = 0; m_nmi_src = 0; m_pend = 0; m_prev = 0; m_tag = "R10";
            m_hist = {};
            for (int i = 0; i < SYNC; i++) m_hist.push_back(1'b0);
        end else begin
            m_sync = m_hist[SYNC-1];
            m_rise = m_sync && !m_prev;
            m_prev = m_sync;
            m_hist.push_front(nmi_pin);
            void'(m_hist.pop_back());
            m_clr      = m_valid && irq_ack && m_nmi_src;
            m_old_pend = m_pend;
            m_pend     = (m_pend && !m_clr) || m_rise;
            if (m_valid) begin
                if (irq_ack) begin m_valid = 0; m_nmi_src = 0; m_tag = "R10"; end
            end else if (ex_done) begin
                if (ex_div_err)                take(8'h00, "R2", 0);
                else if (ex_swi)               take(swi_num, "R7", 0);
                else if (ex_brk)               take(8'h03, "R5", 0);
                else if (ex_into && of_flag)   take(8'h04, "R6", 0);
                else if (m_old_pend)           take(8'h02, "R4", 1);
                else if (intr_pin && if_flag)  take(intr_type, "R8", 0);
                else if (tf_flag)              take(8'h01, "R3", 0);
            end
        end
    end

    task automatic compare();
        vectors++;
        if (irq_valid !== m_valid || (m_valid && irq_type !== m_type)) begin
            fails++;
            $display("FAIL %s %s: valid=%0b type=%02h expected valid=%0b type=%02h",
                     cur_req, m_tag, irq_valid, irq_type, m_valid, m_type);
        end
    endtask

    // One cycle: compare at the falling edge, then return strobes to idle.
    task automatic step();
        @(negedge clk);
        compare();
        ex_done = 0; ex_div_err = 0; ex_swi = 0; ex_brk = 0; ex_into = 0; irq_ack = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ack_when_valid();
        for (int i = 0; i < 12 && !irq_valid; i++) step();
        irq_ack = 1;
        step();
        step();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin : stim
        idle(3);
        rst_n = 1;
        cur_req = "R1"; idle(2);

        cur_req = "R2"; ex_done = 1; ex_div_err = 1; step(); ack_when_valid();
        cur_req = "R7"; ex_done = 1; ex_swi = 1; swi_num = 8'hA5; step(); ack_when_valid();
        ex_done = 1; ex_swi = 1; swi_num = 8'hFF; step(); ack_when_valid();
        ex_done = 1; ex_swi = 1; swi_num = 8'h00; step(); ack_when_valid();
        cur_req = "R5"; ex_done = 1; ex_brk = 1; step(); ack_when_valid();
        cur_req = "R6"; ex_done = 1; ex_into = 1; of_flag = 1; step(); ack_when_valid();
        of_flag = 0; ex_done = 1; ex_into = 1; step(); idle(3);
        cur_req = "R3"; tf_flag = 1; ex_done = 1; step(); ack_when_valid(); tf_flag = 0;
        cur_req = "R8"; intr_pin = 1; if_flag = 1; intr_type = 8'h40; ex_done = 1; step(); ack_when_valid();
        if_flag = 0; ex_done = 1; step(); idle(3); intr_pin = 0;

        cur_req = "R4"; nmi_pin = 1; step(); nmi_pin = 0; idle(4);
        ex_done = 1; step(); ack_when_valid();
        nmi_pin = 1; idle(5); ex_done = 1; step(); ack_when_valid();
        ex_done = 1; step(); idle(3); nmi_pin = 0; idle(3);

        cur_req = "R11"; nmi_pin = 1; step(); nmi_pin = 0; step(); nmi_pin = 1; step(); nmi_pin = 0;
        idle(4); ex_done = 1; step(); ack_when_valid();
        ex_done = 1; step(); idle(3);

        cur_req = "R9"; nmi_pin = 1; step(); nmi_pin = 0; idle(4);
        intr_pin = 1; if_flag = 1; intr_type = 8'h77; tf_flag = 1;
        ex_done = 1; ex_div_err = 1; ex_swi = 1; swi_num = 8'h21; ex_brk = 1; ex_into = 1; of_flag = 1;
        step(); ack_when_valid();
        ex_done = 1; ex_swi = 1; swi_num = 8'h21; ex_brk = 1; step(); ack_when_valid();
        ex_done = 1; step(); ack_when_valid();
        ex_done = 1; step(); ack_when_valid();
        intr_pin = 0; ex_done = 1; step(); ack_when_valid();
        tf_flag = 0; of_flag = 0; if_flag = 0;

        cur_req = "R10"; ex_done = 1; ex_brk = 1; step(); idle(2);
        ex_done = 1; ex_div_err = 1; step(); idle(4);
        irq_ack = 1; ex_done = 1; ex_swi = 1; swi_num = 8'h10; step(); idle(3);

        cur_req = "R12"; ex_div_err = 1; ex_brk = 1; tf_flag = 1; intr_pin = 1; if_flag = 1; step();
        idle(3); tf_flag = 0; intr_pin = 0; if_flag = 0;

        cur_req = "R9";
        for (int n = 0; n < 4000; n++) begin
            nmi_pin    = ($urandom_range(0, 15) == 0) ? ~nmi_pin : nmi_pin;
            intr_pin   = $urandom_range(0, 1);
            intr_type  = 8'($urandom);
            if_flag    = $urandom_range(0, 1);
            tf_flag    = ($urandom_range(0, 3) == 0);
            of_flag    = $urandom_range(0, 1);
            ex_done    = $urandom_range(0, 1);
            ex_div_err = ($urandom_range(0, 7) == 0);
            ex_swi     = ($urandom_range(0, 7) == 0);
            swi_num    = 8'($urandom);
            ex_brk     = ($urandom_range(0, 7) == 0);
            ex_into    = ($urandom_range(0, 5) == 0);
            irq_ack    = irq_valid && ($urandom_range(0, 2) == 0);
            step();
        end
        idle(4);
        summary();
        $finish;
    end
endmodule